// File: doc/BRIEF.md
# Dual-Copy Wiper Register Bank

This block is the register file behind a four-channel digital potentiometer. Each channel has a live 7-bit wiper code that drives its output, plus a persistent initial-value code held in the same address slot. A mode bit in the control register at address 8 selects which copy an access at addresses 0 to 3 reaches. Addresses 4 to 6 hold three persistent general-purpose bytes. The persistent array is an ordinary flop array inside the block.

A serial-interface front end presents one byte read or write per cycle and pulses `bus_stop` when the bus transaction ends. An accepted persistent write arms the block. The next STOP starts a timed commit cycle of `NV_TICKS` clock cycles, and the busy flag is visible in the control register for that whole cycle. While the flag is set, the block refuses every write. Only one persistent byte is taken per commit cycle.

Top module: `potbank_regs`

## Requirements
- R1: After reset every wiper code and every initial-value code is 40h, the general-purpose bytes are 00h, the control register reads 40h, `run_en` is 1 and `rdata` is 00h.
- R2: When control bit 7 is 1, a write to address 0 to 3 loads `wdata[6:0]` into that channel's wiper only. A read there returns `{1'b0, wiper}`. The initial-value code is left untouched. Channel n's code appears on `wiper_o[7n+6:7n]`.
- R3: When control bit 7 is 0, a write to address 0 to 3 loads `wdata[6:0]` into both that channel's initial-value code and its wiper. A read there returns `{1'b0, initial value}`.
- R4: Addresses 4, 5 and 6 are full 8-bit persistent bytes. They can be written and read whatever the value of control bit 7.
- R5: The control register at address 8 reads as {mode bit 7, run bit 6, busy bit 5, bits 4 to 0 zero}. Bits 7 and 6 are writable and bit 5 is read-only. `run_en` follows bit 6, where 0 means shutdown.
- R6: A `bus_stop` pulse that follows an accepted persistent write raises the busy bit in the next cycle. The bit then stays high for exactly `NV_TICKS` cycles. A `bus_stop` pulse with no persistent write pending leaves the busy bit at 0.
- R7: While the busy bit is 1, every write is refused: writes to wipers, to the control register and to persistent bytes all have no effect.
- R8: Once one persistent write has been accepted, further persistent writes are ignored until the commit cycle that it started has finished.
- R9: Address 7 and addresses 9 to 15 read as 00h, and writes to them have no effect.
- R10: `rdata` is registered. It takes the addressed value at the clock edge that samples `rd_en`, and it holds that value through cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| bus_stop | input | 1 | One-cycle pulse at bus STOP |
| rdata | output | 8 | Registered read data |
| wiper_o | output | 28 | Packed live wiper codes, channel 0 in the low bits |
| run_en | output | 1 | 1 = channels active, 0 = shutdown |

## Verification
A write strobed at one clock edge is seen in `wiper_o`, `run_en` and any later read from the next edge onward. A read result shows on `rdata` right after the edge that samples `rd_en`. The bench drives each operation for exactly one cycle, starting at a falling edge, and compares outputs at the following falling edge, so each check sees one settled register stage. For the busy window, the control register is read in every cycle after the STOP pulse, and the number of reads that show the busy bit is counted. That count must equal `NV_TICKS` exactly, because each such read samples the flag one edge after it changes.

// File: rtl/potbank_regs.sv
module potbank_regs #(
  parameter int NCH      = 4,
  parameter int WW       = 7,
  parameter int NGP      = 3,
  parameter int NV_TICKS = 2500000,
  parameter logic [WW-1:0] MID = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              bus_stop,
  output logic [7:0]        rdata,
  output logic [NCH*WW-1:0] wiper_o,
  output logic              run_en
);
  localparam int CW  = $clog2(NV_TICKS + 1);
  localparam int CHW = $clog2(NCH);
  localparam int GIW = $clog2(NGP);
  localparam logic [3:0] A_GP  = 4'(NCH);
  localparam logic [3:0] A_RSV = 4'(NCH + NGP);
  localparam logic [3:0] A_CTL = 4'(NCH + NGP + 1);

  logic [WW-1:0] wr_q [NCH];
  logic [WW-1:0] iv_q [NCH];
  logic [7:0]    gp_q [NGP];
  logic          vol_q, run_q, wip_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    rdata_q, rd_val;

  wire is_ch  = addr < A_GP;
  wire is_gp  = (addr >= A_GP) && (addr < A_RSV);
  wire is_ctl = addr == A_CTL;
  wire [CHW-1:0] chi  = addr[CHW-1:0];
  wire [GIW-1:0] gidx = GIW'(addr - A_GP);
  wire wr_ok  = wr_en && !wip_q;
  wire nv_hit = wr_ok && !pend_q && ((is_ch && !vol_q) || is_gp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        wr_q[i] <= MID;
        iv_q[i] <= MID;
      end
      for (int i = 0; i < NGP; i++) gp_q[i] <= '0;
      vol_q  <= 1'b0;
      run_q  <= 1'b1;
      wip_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok && is_ch && vol_q) wr_q[chi] <= wdata[WW-1:0];
      if (nv_hit && is_ch) begin
        iv_q[chi] <= wdata[WW-1:0];
        wr_q[chi] <= wdata[WW-1:0];
      end
      if (nv_hit && is_gp) gp_q[gidx] <= wdata;
      if (wr_ok && is_ctl) begin
        vol_q <= wdata[7];
        run_q <= wdata[6];
      end
      if (nv_hit) begin
        pend_q <= 1'b1;
      end else if (bus_stop && pend_q) begin
        pend_q <= 1'b0;
        wip_q  <= 1'b1;
        cnt_q  <= CW'(NV_TICKS - 1);
      end else if (wip_q) begin
        if (cnt_q == '0) wip_q <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (is_ch) rd_val = 8'(vol_q ? wr_q[chi] : iv_q[chi]);
    else if (is_gp) rd_val = gp_q[gidx];
    else if (is_ctl) rd_val = {vol_q, run_q, wip_q, 5'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata  = rdata_q;
  assign run_en = run_q;

  for (genvar g = 0; g < NCH; g++) begin : g_wip
    assign wiper_o[g*WW +: WW] = wr_q[g];
  end

  a_r3_copy_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ch && !vol_q && !wip_q && !pend_q) |=>
      (iv_q[$past(chi)] == $past(wdata[WW-1:0])) && (wr_q[$past(chi)] == $past(wdata[WW-1:0])));
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && cnt_q != '0) |=> wip_q);
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> $past(bus_stop));
  a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && wr_en) |=> ($stable(wiper_o) && $stable(run_en)));
  a_r8_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (pend_q || wip_q));
  a_r9_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RSV) |=> rdata == 8'h00);
endmodule

// File: tb/sim_potbank_regs.sv
`timescale 1ns/1ps
module sim_potbank_regs;
  localparam int TICKS = 20;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, bus_stop = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [27:0] wiper_o;
  logic run_en;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  potbank_regs #(.NV_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .bus_stop(bus_stop), .rdata(rdata), .wiper_o(wiper_o), .run_en(run_en));

  // {req[3:0], op[1:0] (0 wr,1 rd,2 stop,3 idle), addr[3:0], data[7:0], exp[7:0]}
  localparam int NV = 26;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1, 2'd1, 4'd8,  8'h00, 8'h40},  // R1
    {4'd1, 2'd1, 4'd0,  8'h00, 8'h40},  // R1
    {4'd1, 2'd1, 4'd6,  8'h00, 8'h00},  // R1
    {4'd5, 2'd0, 4'd8,  8'hC0, 8'h00},  // R5
    {4'd5, 2'd1, 4'd8,  8'h00, 8'hC0},  // R5
    {4'd2, 2'd0, 4'd1,  8'hFF, 8'h00},  // R2
    {4'd2, 2'd1, 4'd1,  8'h00, 8'h7F},  // R2
    {4'd5, 2'd0, 4'd8,  8'h40, 8'h00},  // R5
    {4'd2, 2'd1, 4'd1,  8'h00, 8'h40},  // R2 initial value untouched
    {4'd3, 2'd0, 4'd2,  8'h15, 8'h00},  // R3
    {4'd6, 2'd2, 4'd0,  8'h00, 8'h00},  // R6
    {4'd6, 2'd1, 4'd8,  8'h00, 8'h60},  // R6 busy visible
    {4'd6, 2'd3, 4'd0,  8'd25, 8'h00},  // R6
    {4'd6, 2'd1, 4'd8,  8'h00, 8'h40},  // R6 busy cleared
    {4'd3, 2'd1, 4'd2,  8'h00, 8'h15},  // R3
    {4'd5, 2'd0, 4'd8,  8'hC0, 8'h00},  // R5
    {4'd3, 2'd1, 4'd2,  8'h00, 8'h15},  // R3 wiper copy
    {4'd4, 2'd0, 4'd5,  8'hA5, 8'h00},  // R4 with mode bit 1
    {4'd4, 2'd2, 4'd0,  8'h00, 8'h00},  // R4
    {4'd4, 2'd3, 4'd0,  8'd25, 8'h00},  // R4
    {4'd4, 2'd1, 4'd5,  8'h00, 8'hA5},  // R4
    {4'd9, 2'd0, 4'd7,  8'hFF, 8'h00},  // R9
    {4'd9, 2'd1, 4'd7,  8'h00, 8'h00},  // R9
    {4'd9, 2'd0, 4'd12, 8'hFF, 8'h00},  // R9
    {4'd9, 2'd1, 4'd12, 8'h00, 8'h00},  // R9
    {4'd9, 2'd1, 4'd8,  8'h00, 8'hC0}   // R9 control untouched
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic [3:0] a, input logic [7:0] d);
    if (k == 2'd3) begin
      repeat (int'(d)) @(negedge clk);
    end else begin
      addr = a; wdata = d;
      wr_en = (k == 2'd0); rd_en = (k == 2'd1); bus_stop = (k == 2'd2);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; bus_stop = 1'b0;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int busy_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata", 32'(rdata), 32'h00);
    check("R1 wipers", 32'(wiper_o), {4'h0, {4{7'h40}}});
    check("R1 run_en", 32'(run_en), 32'h1);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][21:20], VEC[i][19:16], VEC[i][15:8]);
      if (VEC[i][21:20] == 2'd1)
        check($sformatf("R%0d vec%0d", VEC[i][25:22], i), 32'(rdata), 32'(VEC[i][7:0]));
    end
    check("R2 R3 wipers", 32'(wiper_o), {4'h0, 7'h40, 7'h15, 7'h7F, 7'h40});

    op(2'd0, 4'd8, 8'h40); op(2'd3, 4'd0, 8'd3);
    check("R10 rdata hold", 32'(rdata), 32'hC0);

    op(2'd0, 4'd8, 8'h80);
    check("R5 shutdown", 32'(run_en), 32'h0);
    op(2'd1, 4'd8, 8'h00);
    check("R5 readback", 32'(rdata), 32'h80);
    op(2'd0, 4'd8, 8'h40);
    check("R5 run", 32'(run_en), 32'h1);

    op(2'd2, 4'd0, 8'h00); op(2'd1, 4'd8, 8'h00);
    check("R6 idle stop", 32'(rdata), 32'h40);

    op(2'd0, 4'd3, 8'h22); op(2'd2, 4'd0, 8'h00);
    op(2'd0, 4'd8, 8'hC0); op(2'd0, 4'd3, 8'h55); op(2'd0, 4'd0, 8'h77); op(2'd0, 4'd5, 8'h01);
    check("R7 wipers", 32'(wiper_o), {4'h0, 7'h22, 7'h15, 7'h7F, 7'h40});
    op(2'd3, 4'd0, 8'd25);
    op(2'd1, 4'd8, 8'h00); check("R7 control", 32'(rdata), 32'h40);
    op(2'd1, 4'd3, 8'h00); check("R7 ivr3", 32'(rdata), 32'h22);
    op(2'd1, 4'd5, 8'h00); check("R7 gp5", 32'(rdata), 32'hA5);

    op(2'd0, 4'd0, 8'h11); op(2'd0, 4'd1, 8'h22); op(2'd2, 4'd0, 8'h00);
    busy_n = 0;
    for (int j = 0; j < 100; j++) begin
      op(2'd1, 4'd8, 8'h00);
      if (!rdata[5]) break;
      busy_n++;
    end
    check("R6 busy length", 32'(busy_n), 32'(TICKS));
    op(2'd1, 4'd0, 8'h00); check("R8 first", 32'(rdata), 32'h11);
    op(2'd1, 4'd1, 8'h00); check("R8 second", 32'(rdata), 32'h40);
    check("R8 wipers", 32'(wiper_o), {4'h0, 7'h22, 7'h15, 7'h7F, 7'h11});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule